// File: doc/BRIEF.md
# Dual-Mode Shift-Add Constant Multiplier

This combinational block multiplies an unsigned operand N by one of two constants, 2^k+1 or 2^k−1, using one carry-ripple addition and no multiplier array. A single select bit chooses the constant. The shift by k costs nothing in hardware because it is wiring.

In the plus setting, N is added to a copy of itself moved up by k positions. In the minus setting, the bit complement of N is added to the shifted copy. The carry into bit 0 is forced to one, which completes the two's-complement negation. The positions below k see a zero from the shifted copy, so they use half-adder cells. The positions above the operand see a constant from the complemented addend, so they also use reduced cells. Only the overlap region uses full adders.

The operand width and k are independent parameters. The width does not need to be a multiple of k. The result port is n+k+1 bits wide, so neither product can overflow it.

Top module: `shift_add_cmul`

## Requirements
- R1: With `sub_mode` = 0, `prod_out` equals N·(2^k+1) exactly, with N read as unsigned.
- R2: With `sub_mode` = 1, `prod_out` equals N·(2^k−1) exactly, with N read as unsigned.
- R3: `prod_out` is WIDTH+SHIFT+1 bits wide. For an all-ones operand in mode 0, the output is (2^n−1)·(2^k+1) with no lost bits.
- R4: An operand of zero yields a product of zero in both modes.
- R5: In mode 0, bits [k−1:0] of the product equal bits [k−1:0] of N.
- R6: In mode 1, the top product bit (bit n+k) is always 0.
- R7: In both modes, product bit 0 equals operand bit 0.
- R8: The block is correct for any width n ≥ 1 and any k ≥ 1, including when n is not a multiple of k. With k = 1 the two modes give 3N and N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_in | input | WIDTH | Unsigned operand N |
| sub_mode | input | 1 | 0 selects 2^k+1, 1 selects 2^k−1 |
| prod_out | output | WIDTH+SHIFT+1 | Product |

## Verification
The bench builds two copies of the block.

The first copy uses an 8-bit operand with k = 3. Here 8 is not a multiple of 3, and all three cell regions are present. All 256 operands are swept in both modes.

The second copy uses a 6-bit operand with k = 1. This is the narrowest shift, where the half-adder region is a single bit. It is also swept exhaustively, which brings the 3N and N products and every carry length within reach.

// File: rtl/shift_add_cmul.sv
module shift_add_cmul #(
  parameter int WIDTH = 8,
  parameter int SHIFT = 3
) (
  input  logic [WIDTH-1:0]     op_in,
  input  logic                 sub_mode,
  output logic [WIDTH+SHIFT:0] prod_out
);
  localparam int PW = WIDTH + SHIFT + 1;

  logic [PW-1:0] shl;
  logic [PW-1:0] addend;
  logic [PW-1:0] cy;

  assign shl    = {1'b0, op_in, {SHIFT{1'b0}}};
  assign addend = {{(SHIFT+1){sub_mode}}, op_in ^ {WIDTH{sub_mode}}};
  assign cy[0]  = sub_mode;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    logic s, c;
    if (i < SHIFT) begin : g_low
      assign s = addend[i] ^ cy[i];
      assign c = addend[i] & cy[i];
    end else if (i >= WIDTH) begin : g_const
      assign s = shl[i] ^ sub_mode ^ cy[i];
      assign c = sub_mode ? (shl[i] | cy[i]) : (shl[i] & cy[i]);
    end else begin : g_full
      assign s = shl[i] ^ addend[i] ^ cy[i];
      assign c = (shl[i] & addend[i]) | (cy[i] & (shl[i] ^ addend[i]));
    end
    assign prod_out[i] = s;
    if (i < PW - 1) begin : g_link
      assign cy[i+1] = c;
    end else begin : g_end
      logic unused_c;
      assign unused_c = c;
    end
  end
endmodule

// File: rtl/shift_add_cmul_chk.sv
module shift_add_cmul_chk #(
  parameter int WIDTH = 8,
  parameter int SHIFT = 3
) (
  input logic [WIDTH-1:0]     op_in,
  input logic                 sub_mode,
  input logic [WIDTH+SHIFT:0] prod_out
);
  localparam int PW = WIDTH + SHIFT + 1;
  logic [PW-1:0] ext, want;

  always_comb begin
    ext  = PW'(op_in);
    want = sub_mode ? (ext << SHIFT) - ext : (ext << SHIFT) + ext;
    if (!$isunknown({op_in, sub_mode, prod_out})) begin
      // R1
      plus_product_chk: assert (sub_mode || prod_out == want);
      // R2
      minus_product_chk: assert (!sub_mode || prod_out == want);
      // R4
      zero_operand_chk: assert (op_in != '0 || prod_out == '0);
      // R5
      low_passthru_chk: assert (sub_mode || prod_out[SHIFT-1:0] == ext[SHIFT-1:0]);
      // R6
      minus_top_clear_chk: assert (!sub_mode || !prod_out[PW-1]);
      // R7
      parity_chk: assert (prod_out[0] == op_in[0]);
    end
  end
endmodule

bind shift_add_cmul shift_add_cmul_chk #(.WIDTH(WIDTH), .SHIFT(SHIFT)) chk_i (.*);

// File: tb/shift_add_cmul_test.sv
`timescale 1ns/1ps
module shift_add_cmul_test;
  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic [7:0]  a_op;  logic a_md;  logic [11:0] a_pr;
  logic [5:0]  b_op;  logic b_md;  logic [7:0]  b_pr;

  shift_add_cmul #(.WIDTH(8), .SHIFT(3)) uut    (.op_in(a_op), .sub_mode(a_md), .prod_out(a_pr));
  shift_add_cmul #(.WIDTH(6), .SHIFT(1)) uut_k1 (.op_in(b_op), .sub_mode(b_md), .prod_out(b_pr));

  int tests = 0, fails = 0;

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_a(logic [7:0] v, logic m);
    @(negedge clk); a_op = v; a_md = m; #5;
  endtask

  task automatic drive_b(logic [5:0] v, logic m);
    @(negedge clk); b_op = v; b_md = m; #5;
  endtask

  task automatic t_reset;
    // R4: operands held at zero through reset give zero products
    check("R4 reset k3", longint'(a_pr), 0);
    check("R4 reset k1", longint'(b_pr), 0);
  endtask

  task automatic t_corners;
    drive_a(8'hFF, 1'b0); check("R3 all-ones plus", longint'(a_pr), 255*9);
    drive_a(8'hFF, 1'b1); check("R2 all-ones minus", longint'(a_pr), 255*7);
    check("R6 top bit minus", longint'(a_pr[11]), 0);
    drive_a(8'h01, 1'b0); check("R1 one plus", longint'(a_pr), 9);
    drive_a(8'h01, 1'b1); check("R2 one minus", longint'(a_pr), 7);
    drive_a(8'h00, 1'b1); check("R4 zero minus", longint'(a_pr), 0);
    drive_a(8'h00, 1'b0); check("R4 zero plus", longint'(a_pr), 0);
    drive_b(6'h3F, 1'b0); check("R8 k1 all-ones 3N", longint'(b_pr), 63*3);
    drive_b(6'h3F, 1'b1); check("R8 k1 all-ones N", longint'(b_pr), 63);
  endtask

  task automatic t_mode_toggle;
    drive_a(8'hA5, 1'b0); check("R1 toggle plus", longint'(a_pr), 165*9);
    check("R5 low bits", longint'(a_pr[2:0]), 5);
    drive_a(8'hA5, 1'b1); check("R2 toggle minus", longint'(a_pr), 165*7);
    check("R7 parity", longint'(a_pr[0]), 1);
  endtask

  task automatic t_sweep_k3;
    for (int v = 0; v < 256; v++) begin
      drive_a(v[7:0], 1'b0);
      check("R1 sweep", longint'(a_pr), v*9);
      check("R5 sweep", longint'(a_pr[2:0]), v % 8);
      drive_a(v[7:0], 1'b1);
      check("R2 sweep", longint'(a_pr), v*7);
      check("R7 sweep", longint'(a_pr[0]), v % 2);
    end
  endtask

  task automatic t_sweep_k1;
    for (int v = 0; v < 64; v++) begin
      drive_b(v[5:0], 1'b0);
      check("R8 k1 3N", longint'(b_pr), v*3);
      drive_b(v[5:0], 1'b1);
      check("R8 k1 N", longint'(b_pr), v);
      check("R6 k1 top", longint'(b_pr[7]), 0);
    end
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    a_op = '0; a_md = 0; b_op = '0; b_md = 0;
    repeat (3) @(posedge clk);
    #5 t_reset();
    rst = 0;
    t_corners();
    t_mode_toggle();
    t_sweep_k3();
    t_sweep_k1();
    finish_run();
  end

  initial begin
    #(20 * 100000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule